// File: doc/BRIEF.md
# Link-Start Latency Meter

This block measures how many link clock cycles pass between the moment a receiver stops requesting synchronization and the moment its first user data comes out. It watches two signals in the link clock domain: the active-low synchronization request and the receiver's link-valid indication. A drop and release of the request starts a measurement. The first link-valid seen after that ends it. One result is captured per link bring-up.

The captured count, a done flag and a saturation flag are held until the next reset. Every reset re-arms the block. Bringing a link up repeatedly, with resets or power cycles in between, therefore gives a set of numbers that can be compared. A sound deterministic-latency setup gives the same value each time, give or take one cycle from word alignment. Typical values lie between a few dozen and a few hundred cycles. If the request is raised again before link-valid appears, the bring-up is treated as abandoned and counting restarts from zero at the next release.

Top module: `lsm_latency_meter`

## Requirements
- R1: While `rst_n` is sampled low, and on the first edge after it, `lat_count` is 0 and both `lat_done` and `lat_sat` are 0.
- R2: A measurement starts on the clock edge that samples `sync_req_n` high after an edge that sampled it low. A `sync_req_n` that has stayed high since reset starts nothing.
- R3: Let the start edge be edge 0. If `link_valid` is first sampled high at edge k (k >= 0), then `lat_count` becomes k and `lat_done` rises after that edge. Between the start edge and that edge, `lat_count` shows the number of edges elapsed since the start edge.
- R4: Once `lat_done` is 1, it and `lat_count` hold until reset, whatever `sync_req_n` and `link_valid` do.
- R5: An edge that samples `sync_req_n` low before `lat_done` clears `lat_count` and `lat_sat` to 0 and returns to waiting for a release. This holds even if `link_valid` is high on that same edge.
- R6: `lat_count` (12 bits by default) stops at all-ones (4095) and never wraps. `lat_sat` rises on the edge where the count reaches all-ones, so a latency of 4095 or more reads 4095 with `lat_sat` = 1. A latency of 4094 reads 4094 with `lat_sat` = 0.
- R7: `link_valid` sampled high while no measurement is running has no effect: `lat_done` stays 0 and `lat_count` stays 0.
- R8: A reset after a completed measurement clears the result, and the next bring-up is measured afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset; re-arms the measurement |
| sync_req_n | input | 1 | Active-low synchronization request from the receiver |
| link_valid | input | 1 | High when the receiver outputs user data |
| lat_count | output | CNT_W | Running count, and the held result once `lat_done` is set |
| lat_done | output | 1 | Result captured and held |
| lat_sat | output | 1 | Count reached all-ones |

## Verification
Two pairs of events can be presented to the block on the same edge. The first pair is a request re-assertion together with link-valid. The bench drives both low-going request and rising link-valid in the same low clock phase during a running count, and it expects the restart to win: count 0, done low. The second pair is the release edge together with link-valid. The bench raises both in the same phase and expects a held result of exactly 0. The saturating edge is probed at latencies of 4094, 4095 and 5000 to separate the last increment from the clamp.

// File: rtl/lsm_pkg.sv
// Package: shared types for the link-start latency meter.
// Assumes: nothing beyond a single link clock domain.
package lsm_pkg;

    // Measurement phase of the controller.
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,   // waiting for a request release
        ST_RUN  = 2'd1,   // counting link clocks
        ST_HOLD = 2'd2    // result captured, frozen until reset
    } lsm_state_t;

endpackage

// File: rtl/lsm_release_det.sv
// Module: detects the release of an active-low request.
// Produces a one-cycle pulse on the combinational output when the current
// sample is high and the previous registered sample was low.
// Assumes: req_n is already in the clk domain. The previous-sample register
// resets high, so a request that stays high out of reset yields no pulse.
module lsm_release_det (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic release_p,
    output logic req_low
);

    logic prev_q;

    // Keep the previous sample of the request.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= req_n;
    end

    // Release is a low-to-high transition of the active-low request.
    always_comb begin
        release_p = req_n & ~prev_q;
        req_low   = ~req_n;
    end

endmodule

// File: rtl/lsm_satcnt.sv
// Module: saturating up-counter with synchronous clear.
// Clear has priority over increment. The counter stops at all-ones and
// reports, on the increment that lands on all-ones, a hit pulse.
// Assumes: W >= 2.
module lsm_satcnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         hit_max
);

    localparam logic [W-1:0] MAXV  = {W{1'b1}};
    localparam logic [W-1:0] PREV  = MAXV - 1'b1;

    logic [W-1:0] cnt_q;
    logic         at_max;

    // Flag the all-ones value and the increment that reaches or holds it.
    always_comb begin
        at_max  = (cnt_q == MAXV);
        hit_max = inc & ~clr & ((cnt_q == PREV) | at_max);
    end

    // Count register: clear, else increment unless already at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clr)             cnt_q <= '0;
        else if (inc && !at_max)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/lsm_ctrl.sv
// Module: measurement controller for the link-start latency meter.
// Decides when the counter is cleared and advanced, when the result is
// frozen, and keeps the sticky saturation flag.
// Assumes: release_p is a one-cycle pulse. A request re-assertion beats
// link-valid on the same edge. Once frozen, nothing but reset leaves HOLD.
module lsm_ctrl
    import lsm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic release_p,
    input  logic req_low,
    input  logic link_valid,
    input  logic hit_max,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic done,
    output logic sat
);

    lsm_state_t state_q, state_d;
    logic       sat_q, sat_d;

    // Next-state and counter control for each phase.
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        sat_d   = sat_q;
        unique case (state_q)
            ST_WAIT: begin
                cnt_clr = 1'b1;
                sat_d   = 1'b0;
                if (release_p) begin
                    state_d = link_valid ? ST_HOLD : ST_RUN;
                end
            end
            ST_RUN: begin
                if (req_low) begin
                    cnt_clr = 1'b1;
                    sat_d   = 1'b0;
                    state_d = ST_WAIT;
                end else begin
                    cnt_inc = 1'b1;
                    sat_d   = sat_q | hit_max;
                    if (link_valid) state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                state_d = ST_HOLD;
            end
            default: begin
                state_d = ST_WAIT;
                cnt_clr = 1'b1;
                sat_d   = 1'b0;
            end
        endcase
    end

    // Phase and saturation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            sat_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sat_q   <= sat_d;
        end
    end

    // Done is the frozen phase itself.
    always_comb begin
        done = (state_q == ST_HOLD);
        sat  = sat_q;
    end

endmodule

// File: rtl/lsm_latency_meter.sv
// Module: link-start latency meter (top).
// Counts link clock edges from the release of the active-low sync request
// to the first sampled link-valid and holds the result until reset.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous, active low.
module lsm_latency_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_req_n,
    input  logic             link_valid,
    output logic [CNT_W-1:0] lat_count,
    output logic             lat_done,
    output logic             lat_sat
);

    logic release_p;
    logic req_low;
    logic cnt_clr;
    logic cnt_inc;
    logic hit_max;

    lsm_release_det u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (sync_req_n),
        .release_p (release_p),
        .req_low   (req_low)
    );

    lsm_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .release_p  (release_p),
        .req_low    (req_low),
        .link_valid (link_valid),
        .hit_max    (hit_max),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .done       (lat_done),
        .sat        (lat_sat)
    );

    lsm_satcnt #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .cnt     (lat_count),
        .hit_max (hit_max)
    );

endmodule

// File: rtl/lsm_latency_checker.sv
// Module: property checker for the link-start latency meter, bound to the top.
// Assumes: observes the top-level ports only.
module lsm_latency_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_req_n,
    input logic             link_valid,
    input logic [CNT_W-1:0] lat_count,
    input logic             lat_done,
    input logic             lat_sat
);

    localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (lat_count == '0 && !lat_done && !lat_sat)); // R1

    AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_done) |-> $past(link_valid)); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lat_done |=> lat_done); // R4

    AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lat_done |=> $stable(lat_count)); // R4

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_req_n && !lat_done) |=> (lat_count == '0 && !lat_done && !lat_sat)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_count == ALL1 && sync_req_n) |=> (lat_count == ALL1)); // R6

    AST_SAT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        lat_sat |-> (lat_count == ALL1)); // R6

endmodule

bind lsm_latency_meter lsm_latency_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_req_n (sync_req_n),
    .link_valid (link_valid),
    .lat_count  (lat_count),
    .lat_done   (lat_done),
    .lat_sat    (lat_sat)
);

// File: tb/sim_lsm_latency_meter.sv
module sim_lsm_latency_meter;

    localparam int CW = 12;
    localparam int NV = 10;
    localparam int VK   [NV] = '{0, 1, 2, 5, 67, 99, 115, 195, 4094, 4095};
    localparam int VEXP [NV] = '{0, 1, 2, 5, 67, 99, 115, 195, 4094, 4095};
    localparam int VSAT [NV] = '{0, 0, 0, 0, 0,  0,  0,   0,   0,    1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_req_n = 1'b1;
    logic          link_valid = 1'b0;
    logic [CW-1:0] lat_count;
    logic          lat_done;
    logic          lat_sat;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lsm_latency_meter #(.CNT_W(CW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_req_n (sync_req_n),
        .link_valid (link_valid),
        .lat_count  (lat_count),
        .lat_done   (lat_done),
        .lat_sat    (lat_sat)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sync_req_n = 1'b1; link_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Request low, release, link-valid sampled on the k-th edge after start.
    task automatic measure(input int k, input string req);
        sync_req_n = 1'b0;
        repeat (2) @(negedge clk);
        sync_req_n = 1'b1;
        if (k == 0) link_valid = 1'b1;
        @(posedge clk);
        if (k > 0) begin
            repeat (k - 1) @(posedge clk);
            @(negedge clk);
            if (k >= 2 && k < 4096) begin
                chk({req, " running count"}, int'(lat_count), k - 1);
                chk({req, " not done early"}, int'(lat_done), 0);
            end
            link_valid = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        link_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 count", int'(lat_count), 0);
        chk("R1 done", int'(lat_done), 0);
        chk("R1 sat", int'(lat_sat), 0);

        // Vector table walk: R3 values, R6 boundary, R8 re-arm
        for (int i = 0; i < NV; i++) begin
            do_reset();
            chk("R8 rearm done", int'(lat_done), 0);
            measure(VK[i], "R3");
            chk("R3 result", int'(lat_count), VEXP[i]);
            chk("R3 done", int'(lat_done), 1);
            chk("R6 sat", int'(lat_sat), VSAT[i]);
        end

        // R6: well past saturation, no wrap
        do_reset();
        measure(5000, "R6");
        chk("R6 clamp", int'(lat_count), 4095);
        chk("R6 sat flag", int'(lat_sat), 1);

        // R2: request high since reset starts nothing; R7 valid ignored
        do_reset();
        repeat (5) @(negedge clk);
        link_valid = 1'b1;
        repeat (3) @(negedge clk);
        link_valid = 1'b0;
        @(negedge clk);
        chk("R2 no start done", int'(lat_done), 0);
        chk("R2 no start count", int'(lat_count), 0);
        sync_req_n = 1'b0;
        @(negedge clk);
        link_valid = 1'b1;
        repeat (2) @(negedge clk);
        link_valid = 1'b0;
        @(negedge clk);
        chk("R7 valid while waiting done", int'(lat_done), 0);
        chk("R7 valid while waiting count", int'(lat_count), 0);

        // R4: hold after done
        do_reset();
        measure(20, "R4");
        sync_req_n = 1'b0;
        repeat (3) @(negedge clk);
        sync_req_n = 1'b1;
        link_valid = 1'b1;
        repeat (4) @(negedge clk);
        link_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 held count", int'(lat_count), 20);
        chk("R4 held done", int'(lat_done), 1);

        // R5: restart from zero before valid
        do_reset();
        sync_req_n = 1'b0;
        repeat (2) @(negedge clk);
        sync_req_n = 1'b1;
        @(posedge clk);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R5 running before restart", int'(lat_count), 10);
        sync_req_n = 1'b0;
        @(negedge clk);
        chk("R5 cleared", int'(lat_count), 0);
        chk("R5 not done", int'(lat_done), 0);
        measure(7, "R5");
        chk("R5 after restart", int'(lat_count), 7);

        // R5: re-assertion and valid on the same edge, restart wins
        do_reset();
        sync_req_n = 1'b0;
        repeat (2) @(negedge clk);
        sync_req_n = 1'b1;
        repeat (5) @(negedge clk);
        sync_req_n = 1'b0;
        link_valid = 1'b1;
        @(negedge clk);
        link_valid = 1'b0;
        chk("R5 same edge done", int'(lat_done), 0);
        chk("R5 same edge count", int'(lat_count), 0);

        finished = 1'b1;
        summary();
    end

endmodule